// File: doc/BRIEF.md
# Two-Stage Card Clock Generator

This block makes the clock for a memory card from the host's reference clock. It also makes two strobes that tell the command and data logic when to launch a bit (drive) and when to capture one (sample). Two dividers are chained:

- The first stage divides the reference by its divider field plus one. It also picks a coarse drive point and a coarse sample point, both counted in reference cycles inside its period.
- The second stage divides the first-stage period by twice its own divider field. It picks a fine drive point and a fine sample point, both counted in first-stage periods.

All logic runs on the reference clock. The card clock is a registered signal, and both strobes are one-reference-cycle enable pulses.

Software presents the new settings on the input ports and raises a start flag together with an update-only flag. The block captures the settings at once and holds them as pending. It moves them into the working set at the next card-clock period boundary, so the card clock never gets a shortened or stretched pulse. When the low-power setting is on, the clock parks low while the bus reports idle and starts again once activity returns. Typical use is roughly 400 kHz while the card is being identified and 25 MHz after that.

Top module: `card_clock_gen`

## Requirements
- R1: When the second-stage divider field D2 is 0, the second stage is bypassed. The card clock then has a period of D1+1 reference cycles, where D1 is the first-stage divider field. It is high for the first floor(D1/2)+1 cycles of each period.
- R2: When D2 is not 0, the card clock has a period of (D1+1)*2*D2 reference cycles. It is high while the second-stage count is below D2, that is, for the first (D1+1)*D2 cycles of the period.
- R3: The drive strobe is a one-cycle pulse. It fires when the first-stage count equals the coarse drive field and, if D2 is not 0, the second-stage count also equals the fine drive field. Its offset from the card-clock rise is therefore coarse + fine*(D1+1) reference cycles.
- R4: The sample strobe follows the same rule as R3, using the coarse and fine sample fields.
- R5: While the working clock-enable setting is 0, the card clock stays low and neither strobe fires.
- R6: When the working low-power setting is 1 and bus_idle_i is high at a period boundary, the clock stops low. It restarts from the beginning of a period at the first evaluation that finds bus_idle_i low.
- R7: A request is upd_start_i and upd_clk_only_i both high in the same cycle. It captures every setting input and raises start_busy_o on the next cycle. If a later request arrives while one is still pending, the later one wins.
- R8: A start flag without the update-only flag is ignored: it captures nothing and leaves start_busy_o low.
- R9: The working settings change only at a card-clock period boundary, or in any cycle while the clock is stopped. start_busy_o clears on the cycle those settings are taken.
- R10: clk_ready_o is high when settings have been accepted at least once, no request is pending, and the clock is running.
- R11: After reset, all outputs are low and the working clock enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_div_i | input | PRE_W | First-stage divider field D1 (ratio D1+1) |
| pre_drv_i | input | PRE_W | Coarse drive point, in reference cycles |
| pre_smp_i | input | PRE_W | Coarse sample point, in reference cycles |
| post_div_i | input | POST_W | Second-stage divider field D2 (ratio 2*D2, 0 = bypass) |
| post_drv_i | input | POST_W | Fine drive point, in first-stage periods; must be below D2 |
| post_smp_i | input | POST_W | Fine sample point, in first-stage periods; must be below D2 |
| clk_en_i | input | 1 | Clock enable setting |
| lowpwr_i | input | 1 | Low-power (stop when idle) setting |
| bus_idle_i | input | 1 | Live indication that the card bus is idle |
| upd_start_i | input | 1 | Start flag |
| upd_clk_only_i | input | 1 | Update-clock-only flag |
| card_clk_o | output | 1 | Card clock |
| drv_o | output | 1 | One-cycle drive strobe |
| smp_o | output | 1 | One-cycle sample strobe |
| start_busy_o | output | 1 | Request pending (self-clearing start flag) |
| clk_ready_o | output | 1 | Settings accepted and clock running |

## Verification
The bench builds the block with PRE_W=4 and POST_W=3. With these widths the largest dividers (D1=15, D2=7) give a period of 224 cycles, so the top of both fields is reached in a short run alongside the bypass and ratio-two corners. The narrow fields also make it quick to test phase points at the last legal fine offset, requests that land mid-period, and low-power stops across several boundaries.

// File: rtl/card_clock_gen.sv
module card_clock_gen #(
  parameter int PRE_W  = 7,
  parameter int POST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  pre_div_i,
  input  logic [PRE_W-1:0]  pre_drv_i,
  input  logic [PRE_W-1:0]  pre_smp_i,
  input  logic [POST_W-1:0] post_div_i,
  input  logic [POST_W-1:0] post_drv_i,
  input  logic [POST_W-1:0] post_smp_i,
  input  logic              clk_en_i,
  input  logic              lowpwr_i,
  input  logic              bus_idle_i,
  input  logic              upd_start_i,
  input  logic              upd_clk_only_i,
  output logic              card_clk_o,
  output logic              drv_o,
  output logic              smp_o,
  output logic              start_busy_o,
  output logic              clk_ready_o
);
  localparam int C2_W  = POST_W + 1;
  localparam int O_PRD = PRE_W;
  localparam int O_PRS = 2 * PRE_W;
  localparam int O_PD  = 3 * PRE_W;
  localparam int O_PDR = O_PD + POST_W;
  localparam int O_PDS = O_PD + 2 * POST_W;
  localparam int O_LP  = O_PD + 3 * POST_W;
  localparam int CFG_W = O_LP + 2;

  logic [CFG_W-1:0] cfg_in, w_cfg, s_cfg, nxt_cfg;
  logic [PRE_W-1:0] c1;
  logic [C2_W-1:0]  c2, last2;
  logic             active_q, pend_q, valid_q;
  logic             req, load, bypass, period_end, hi, drv_hit, smp_hit;

  logic [PRE_W-1:0]  pre_div, pre_drv, pre_smp;
  logic [POST_W-1:0] post_div, post_drv, post_smp;
  logic              w_en;

  assign cfg_in = {clk_en_i, lowpwr_i, post_smp_i, post_drv_i, post_div_i,
                   pre_smp_i, pre_drv_i, pre_div_i};

  assign pre_div  = w_cfg[O_PRD-1:0];
  assign pre_drv  = w_cfg[O_PRS-1:O_PRD];
  assign pre_smp  = w_cfg[O_PD-1:O_PRS];
  assign post_div = w_cfg[O_PDR-1:O_PD];
  assign post_drv = w_cfg[O_PDS-1:O_PDR];
  assign post_smp = w_cfg[O_LP-1:O_PDS];
  assign w_en     = w_cfg[CFG_W-1];

  assign req        = upd_start_i & upd_clk_only_i;
  assign bypass     = (post_div == '0);
  assign last2      = {post_div, 1'b0} - C2_W'(1);
  assign period_end = (c1 == pre_div) & (bypass | (c2 == last2));
  assign load       = ~active_q | period_end;
  assign nxt_cfg    = pend_q ? s_cfg : w_cfg;

  assign hi      = bypass ? (c1 <= (pre_div >> 1)) : (c2 < {1'b0, post_div});
  assign drv_hit = (c1 == pre_drv) & (bypass | (c2 == {1'b0, post_drv}));
  assign smp_hit = (c1 == pre_smp) & (bypass | (c2 == {1'b0, post_smp}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_cfg      <= '0;
      s_cfg      <= '0;
      c1         <= '0;
      c2         <= '0;
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      valid_q    <= 1'b0;
      card_clk_o <= 1'b0;
      drv_o      <= 1'b0;
      smp_o      <= 1'b0;
    end else begin
      card_clk_o <= active_q & hi;
      drv_o      <= active_q & drv_hit;
      smp_o      <= active_q & smp_hit;
      if (load) begin
        if (pend_q) begin
          w_cfg   <= s_cfg;
          valid_q <= 1'b1;
        end
        active_q <= nxt_cfg[CFG_W-1] & ~(nxt_cfg[O_LP] & bus_idle_i);
        c1 <= '0;
        c2 <= '0;
      end else if (c1 == pre_div) begin
        c1 <= '0;
        c2 <= c2 + C2_W'(1);
      end else begin
        c1 <= c1 + PRE_W'(1);
      end
      if (req) begin
        s_cfg  <= cfg_in;
        pend_q <= 1'b1;
      end else if (load) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign start_busy_o = pend_q;
  assign clk_ready_o  = valid_q & ~pend_q & active_q;

  assert_gate_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !w_en |=> (!card_clk_o && !drv_o && !smp_o));
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(w_cfg));
  assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> start_busy_o);
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_start_i && !upd_clk_only_i && !start_busy_o) |=> !start_busy_o);
  assert_strobe_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_o || smp_o || card_clk_o) |-> $past(active_q));
endmodule

// File: tb/card_clock_gen_bench.sv
module card_clock_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int QW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pre_div = '0, pre_drv = '0, pre_smp = '0;
  logic [QW-1:0] post_div = '0, post_drv = '0, post_smp = '0;
  logic clk_en = 1'b0, lowpwr = 1'b0, bus_idle = 1'b0, ustart = 1'b0, uonly = 1'b0;
  logic card_clk, drv, smp, busy, ready;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R11";

  card_clock_gen #(.PRE_W(PW), .POST_W(QW)) u_card_clock_gen (
    .clk(clk), .rst_n(rst_n),
    .pre_div_i(pre_div), .pre_drv_i(pre_drv), .pre_smp_i(pre_smp),
    .post_div_i(post_div), .post_drv_i(post_drv), .post_smp_i(post_smp),
    .clk_en_i(clk_en), .lowpwr_i(lowpwr), .bus_idle_i(bus_idle),
    .upd_start_i(ustart), .upd_clk_only_i(uonly),
    .card_clk_o(card_clk), .drv_o(drv), .smp_o(smp),
    .start_busy_o(busy), .clk_ready_o(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int wd1, wcd, wcs, wd2, wfd, wfs, wen, wlp;
  int sd1, scd, scs, sd2, sfd, sfs, sen, slp;
  int c1, c2, act, pend, valid;
  int m_clk, m_drv, m_smp;

  always @(posedge clk) begin
    if (!rst_n) begin
      {wd1, wcd, wcs, wd2, wfd, wfs, wen, wlp} = '{default: 0};
      {sd1, scd, scs, sd2, sfd, sfs, sen, slp} = '{default: 0};
      c1 = 0; c2 = 0; act = 0; pend = 0; valid = 0;
      m_clk = 0; m_drv = 0; m_smp = 0;
    end else begin
      int byp, at_end, old_pend;
      byp = (wd2 == 0);
      m_clk = act && (byp ? (c1 <= wd1 / 2) : (c2 < wd2));
      m_drv = act && c1 == wcd && (byp || c2 == wfd);
      m_smp = act && c1 == wcs && (byp || c2 == wfs);
      at_end = (c1 == wd1) && (byp || c2 == 2 * wd2 - 1);
      old_pend = pend;
      if (!act || at_end) begin
        if (old_pend) begin
          wd1 = sd1; wcd = scd; wcs = scs; wd2 = sd2; wfd = sfd; wfs = sfs;
          wen = sen; wlp = slp; valid = 1; pend = 0;
        end
        act = wen && !(wlp && bus_idle);
        c1 = 0; c2 = 0;
      end else if (c1 == wd1) begin
        c1 = 0; c2++;
      end else c1++;
      if (ustart && uonly) begin
        sd1 = pre_div; scd = pre_drv; scs = pre_smp;
        sd2 = post_div; sfd = post_drv; sfs = post_smp;
        sen = clk_en; slp = lowpwr; pend = 1;
      end
    end
  end

  task automatic chk(input string what, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", tag, what, act_v, exp_v, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("card_clk", card_clk, m_clk);
      chk("drv", drv, m_drv);
      chk("smp", smp, m_smp);
      chk("busy", busy, pend);
      chk("ready", ready, valid && !pend && act);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setcfg(input int d1, cd, cs, d2, fd, fs, en, lp);
    pre_div = PW'(d1); pre_drv = PW'(cd); pre_smp = PW'(cs);
    post_div = QW'(d2); post_drv = QW'(fd); post_smp = QW'(fs);
    clk_en = en[0]; lowpwr = lp[0];
  endtask

  task automatic request(input bit only);
    @(negedge clk);
    ustart = 1'b1; uonly = only;
    @(negedge clk);
    ustart = 1'b0; uonly = 1'b0;
  endtask

  initial begin
    int hicnt;
    run(3);
    tag = "R11";
    chk("reset card_clk", card_clk, 0);
    chk("reset drv", drv, 0);
    chk("reset busy", busy, 0);
    chk("reset ready", ready, 0);
    rst_n = 1'b1;
    run(5);

    tag = "R5";
    run(10);

    tag = "R2";
    setcfg(2, 1, 0, 3, 2, 1, 1, 0);
    request(1'b1);
    tag = "R7";
    chk("busy after request", busy, 1);
    tag = "R3";
    run(120);

    tag = "R8";
    setcfg(5, 0, 0, 1, 0, 0, 1, 0);
    request(1'b0);
    chk("busy after plain start", busy, 0);
    run(40);

    tag = "R1";
    setcfg(3, 2, 0, 0, 0, 0, 1, 0);
    request(1'b1);
    run(30);
    hicnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hicnt += card_clk;
    end
    chk("bypass high count over 40 cycles", hicnt, 20);

    tag = "R1";
    setcfg(1, 1, 0, 0, 0, 0, 1, 0);
    request(1'b1);
    run(30);

    tag = "R9";
    setcfg(4, 3, 1, 2, 1, 0, 1, 0);
    request(1'b1);
    run(3);
    setcfg(1, 0, 1, 3, 0, 2, 1, 0);
    request(1'b1);
    run(80);

    tag = "R4";
    setcfg(15, 15, 7, 7, 6, 6, 1, 0);
    request(1'b1);
    run(500);

    tag = "R6";
    setcfg(1, 0, 1, 2, 1, 0, 1, 1);
    request(1'b1);
    run(20);
    bus_idle = 1'b1;
    run(30);
    bus_idle = 1'b0;
    run(30);
    bus_idle = 1'b1;
    run(7);
    bus_idle = 1'b0;
    run(25);

    tag = "R10";
    setcfg(0, 0, 0, 1, 0, 0, 1, 0);
    request(1'b1);
    run(20);

    tag = "R5";
    setcfg(2, 0, 0, 2, 0, 0, 0, 0);
    request(1'b1);
    run(40);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule